// File: doc/BRIEF.md
# Slot-Timed Backoff and Idle Tracker

This block is the medium-access timing engine of a wireless MAC. It runs on an 8 MHz tick, so one clock is 1/8 µs. It combines a channel-clear indication, the receive and transmit activity lines and a virtual carrier-sense (NAV) countdown into one "medium idle" decision. While the medium stays idle it divides time into slots. Each slot is a programmable first phase followed by a fixed 2 µs second phase.

The first two idle slots raise a one-slot-idle flag and then a two-slot-idle flag. Each later slot decrements a backoff counter that software loads, and increments an idle-slot counter. Any busy indication freezes the slot countdown wherever it stands. The block also counts airtime: microseconds with receive or transmit active, and microseconds of the current transmission. Software chooses random backoff values and doubles them on retry. It writes the slot length, the backoff value, the NAV reservation and the idle hold-off through a small write port.

Top module: `macslot_engine`

## Requirements
- R1: The slot register (select 0) holds 0x1FE plus the slot length in µs, and resets to 0x1FE+9. On each rise of physical idle (status bit 1), the slot counter loads (length−2)×8 with the phase bit (bit 15) clear. With the default it loads 56.
- R2: When the slot counter's count (bits 14:0) is at 1 or below in phase 1, the counter loads 0x8010 (phase 2, count 16). Status bit 7 mirrors the phase bit. A whole slot lasts length×8 ticks.
- R3: The first slot end after idle begins sets status bit 2 (one-slot idle). The second sets status bit 3 (two-slot idle). Both flags clear on any tick where the medium is not idle. Bit 3 is never set without bit 2.
- R4: Once both flags are set, each slot end decrements the backoff counter and increments the idle-slot counter. The backoff counter saturates at zero.
- R5: While physical idle or NAV idle is low, the slot counter holds its value in either phase.
- R6: A rise of physical idle clears the idle-slot counter. A NAV-only busy period leaves the idle-slot counter unchanged.
- R7: A write of V to select 2 loads a NAV countdown of V×8 ticks. NAV idle (status bit 0) is low while the countdown is nonzero.
- R8: Physical idle is low while the channel-clear input is low or receive or transmit is active. It rises 8×D+1 ticks after the last busy tick. D is written through select 3 and resets to 6.
- R9: The busy counter adds 1 for every 8 ticks on which receive or transmit is active, and holds otherwise.
- R10: The transmit counter clears when transmit becomes active. It then adds 1 for every 8 transmit ticks, counting the start tick.
- R11: A write to select 1 loads the backoff counter. The backoff_zero output and status bit 4 are 1 exactly when the counter is zero.
- R12: After reset the status word is 0x0011. Status bit 5 shows receive activity and status bit 6 shows transmit activity. The slot, backoff, idle-slot, busy and transmit counters all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 slot, 1 backoff, 2 NAV, 3 hold-off |
| cfg_wdata | input | 16 | Write data |
| ch_clear | input | 1 | Channel energy-clear indication |
| rx_active | input | 1 | Receiver active |
| tx_active | input | 1 | Transmitter active |
| status | output | 16 | Status word |
| backoff_zero | output | 1 | Backoff counter is zero |
| slot_count | output | 16 | Slot counter (phase bit 15, count 14:0) |
| backoff_count | output | 16 | Backoff counter |
| idle_slots | output | 16 | Idle slots after the first two |
| busy_us | output | 16 | Microseconds of receive or transmit activity |
| tx_us | output | 16 | Microseconds of the current transmission |

## Verification
The bench builds the block with its default parameters: 16-bit registers, 8 ticks per µs and a 16-tick second phase. It then programs a 3 µs slot and a 1 µs hold-off, so that a full slot takes 24 cycles and many slot ends, the backoff saturation and NAV and receive freezes fit into a short run. A second reset brings the default 9 µs slot and 6 µs hold-off within reach, which checks the reset-time programming of both values.

// File: rtl/macslot_pkg.sv
// Shared definitions for the slot-timed backoff engine.
// Assumes a 16-bit or wider status word.
package macslot_pkg;
    typedef enum logic [1:0] {
        SEL_SLOT    = 2'd0,
        SEL_BACKOFF = 2'd1,
        SEL_NAV     = 2'd2,
        SEL_HOLD    = 2'd3
    } cfg_sel_e;

    localparam int ST_NAV_IDLE  = 0;
    localparam int ST_PHYS_IDLE = 1;
    localparam int ST_ONE_SLOT  = 2;
    localparam int ST_TWO_SLOT  = 3;
    localparam int ST_BO_ZERO   = 4;
    localparam int ST_RX        = 5;
    localparam int ST_TX        = 6;
    localparam int ST_PHASE     = 7;
endpackage

// File: rtl/macslot_csense.sv
// Carrier sense: the NAV countdown and the physical-idle detector with
// programmable hold-off. Assumes one clock is one tick, with TPU ticks per us.
module macslot_csense #(
    parameter int W           = 16,
    parameter int TPU         = 8,
    parameter int DEF_HOLD_US = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ch_clear,
    input  logic         rx_active,
    input  logic         tx_active,
    input  logic         nav_load,
    input  logic [W-1:0] nav_us,
    input  logic         hold_load,
    input  logic [W-1:0] hold_us,
    output logic         phys_idle,
    output logic         nav_idle
);
    localparam int TW = W + $clog2(TPU);

    logic [TW-1:0] nav_q;
    logic [TW-1:0] hold_q;
    logic [TW-1:0] hold_ticks;
    logic [W-1:0]  hold_cfg_q;
    logic          busy_now;

    assign busy_now   = !ch_clear || rx_active || tx_active;
    assign hold_ticks = TW'(hold_cfg_q) * TW'(TPU);
    assign nav_idle   = (nav_q == '0);

    // Hold-off configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_cfg_q <= W'(DEF_HOLD_US);
        else if (hold_load) hold_cfg_q <= hold_us;
    end

    // NAV countdown: load in ticks, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             nav_q <= '0;
        else if (nav_load)      nav_q <= TW'(nav_us) * TW'(TPU);
        else if (nav_q != '0)   nav_q <= nav_q - TW'(1);
    end

    // Physical idle: forced low while busy, raised after the hold-off drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            phys_idle <= 1'b0;
        end else if (busy_now) begin
            hold_q    <= hold_ticks;
            phys_idle <= 1'b0;
        end else if (hold_q != '0) begin
            hold_q    <= hold_q - TW'(1);
        end else begin
            phys_idle <= 1'b1;
        end
    end

    // R8: receive activity always drops physical idle on the next tick.
    p_rx_drops_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |=> !phys_idle)
        else $error("p_rx_drops_idle_r8");

    // R7: a nonzero reservation makes the medium virtually busy.
    p_nav_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nav_load && nav_us != '0) |=> !nav_idle)
        else $error("p_nav_busy_r7");
endmodule

// File: rtl/macslot_slot.sv
// Slot timer: two-phase slot countdown, one/two-slot idle flags, backoff
// decrement and idle-slot count. Assumes the phase bit is the top bit of W.
module macslot_slot #(
    parameter int W         = 16,
    parameter int TPU       = 8,
    parameter int PH2_TICKS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phys_idle,
    input  logic         nav_idle,
    input  logic [W-1:0] slot_len_us,
    input  logic         bo_load,
    input  logic [W-1:0] bo_val,
    output logic [W-1:0] slot_q,
    output logic         one_q,
    output logic         two_q,
    output logic [W-1:0] bo_q,
    output logic [W-1:0] idle_cnt
);
    localparam int CW = W - 1;

    logic          phys_q;
    logic          med_idle;
    logic          phys_rise;
    logic [CW-1:0] ph1_ticks;
    logic [CW-1:0] cnt;
    logic          phase;
    logic          slot_end;
    logic          counting;

    assign med_idle  = phys_idle && nav_idle;
    assign phys_rise = phys_idle && !phys_q;
    assign cnt       = slot_q[CW-1:0];
    assign phase     = slot_q[W-1];
    assign ph1_ticks = (slot_len_us > W'(2)) ? CW'((slot_len_us - W'(2)) * W'(TPU)) : '0;
    assign slot_end  = med_idle && !phys_rise && phase && (cnt <= CW'(1));
    assign counting  = one_q && two_q;

    // Edge detector for the physical idle rise.
    always_ff @(posedge clk) begin
        if (!rst_n) phys_q <= 1'b0;
        else        phys_q <= phys_idle;
    end

    // Two-phase slot countdown, frozen while the medium is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (phys_rise)
            slot_q <= {1'b0, ph1_ticks};
        else if (med_idle) begin
            if (cnt > CW'(1))  slot_q <= {phase, cnt - CW'(1)};
            else if (!phase)   slot_q <= {1'b1, CW'(PH2_TICKS)};
            else               slot_q <= {1'b0, ph1_ticks};
        end
    end

    // Idle-slot flags: set at the first two slot ends, cleared on busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !med_idle) begin
            one_q <= 1'b0;
            two_q <= 1'b0;
        end else if (slot_end) begin
            if (!one_q) one_q <= 1'b1;
            else        two_q <= 1'b1;
        end
    end

    // Backoff counter: software load, saturating decrement per slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 bo_q <= '0;
        else if (bo_load)                           bo_q <= bo_val;
        else if (slot_end && counting && bo_q != '0) bo_q <= bo_q - W'(1);
    end

    // Idle-slot counter: cleared on idle rise, counts slots after the first two.
    always_ff @(posedge clk) begin
        if (!rst_n || phys_rise)           idle_cnt <= '0;
        else if (slot_end && counting)     idle_cnt <= idle_cnt + W'(1);
    end

    // R5: a busy medium freezes the slot counter.
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!med_idle && !phys_rise) |=> $stable(slot_q))
        else $error("p_freeze_r5");

    // R2: entering phase 2 always loads the fixed 2 us count.
    p_ph2_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_q[W-1]) |-> (slot_q[CW-1:0] == CW'(PH2_TICKS)))
        else $error("p_ph2_load_r2");

    // R4: the backoff counter never wraps below zero.
    p_bo_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_q == '0 && !bo_load) |=> (bo_q == '0))
        else $error("p_bo_floor_r4");

    // R3: two-slot idle implies one-slot idle.
    p_two_implies_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        two_q |-> one_q)
        else $error("p_two_implies_one_r3");

    // R6: an idle rise clears the idle-slot counter.
    p_rise_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phys_rise |=> (idle_cnt == '0))
        else $error("p_rise_clears_r6");
endmodule

// File: rtl/macslot_airtime.sv
// Airtime counters: busy microseconds (rx or tx) and microseconds of the
// current transmission. Assumes TPU ticks make one microsecond.
module macslot_airtime #(
    parameter int W   = 16,
    parameter int TPU = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_active,
    input  logic         tx_active,
    output logic [W-1:0] busy_us,
    output logic [W-1:0] tx_us
);
    localparam int FW = (TPU > 1) ? $clog2(TPU) : 1;
    localparam logic [FW-1:0] FRAC_LAST = FW'(TPU - 1);

    logic [FW-1:0] busy_frac;
    logic [FW-1:0] tx_frac;
    logic          tx_q;
    logic          tx_start;

    assign tx_start = tx_active && !tx_q;

    // Transmit edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= tx_active;
    end

    // Busy microseconds: prescale busy ticks into microseconds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_frac <= '0;
            busy_us   <= '0;
        end else if (rx_active || tx_active) begin
            if (busy_frac == FRAC_LAST) begin
                busy_frac <= '0;
                busy_us   <= busy_us + W'(1);
            end else begin
                busy_frac <= busy_frac + FW'(1);
            end
        end
    end

    // Transmit microseconds: restart at each start, the start tick counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_frac <= '0;
            tx_us   <= '0;
        end else if (tx_start) begin
            tx_frac <= FW'(1 % TPU);
            tx_us   <= W'(TPU == 1);
        end else if (tx_active) begin
            if (tx_frac == FRAC_LAST) begin
                tx_frac <= '0;
                tx_us   <= tx_us + W'(1);
            end else begin
                tx_frac <= tx_frac + FW'(1);
            end
        end
    end

    // R10: a new transmission starts its count from zero.
    p_tx_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |=> (tx_us == '0))
        else $error("p_tx_restart_r10");

    // R9: the busy count holds while neither rx nor tx is active.
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_active && !tx_active) |=> $stable(busy_us))
        else $error("p_busy_hold_r9");
endmodule

// File: rtl/macslot_engine.sv
// Top of the slot-timed backoff and idle tracker. Decodes the write port,
// holds the slot-length register and assembles the status word.
// Assumes W >= 16 so the phase bit sits at bit 15 and all status bits fit.
module macslot_engine
    import macslot_pkg::*;
#(
    parameter int W            = 16,
    parameter int TICKS_PER_US = 8,
    parameter int SLOT_BASE    = 'h1FE,
    parameter int DEF_SLOT_US  = 9,
    parameter int DEF_HOLD_US  = 6,
    parameter int PH2_TICKS    = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    input  logic         ch_clear,
    input  logic         rx_active,
    input  logic         tx_active,
    output logic [W-1:0] status,
    output logic         backoff_zero,
    output logic [W-1:0] slot_count,
    output logic [W-1:0] backoff_count,
    output logic [W-1:0] idle_slots,
    output logic [W-1:0] busy_us,
    output logic [W-1:0] tx_us
);
    localparam logic [W-1:0] DEF_SLOT_REG = W'(SLOT_BASE + DEF_SLOT_US);
    localparam logic [W-1:0] BASE_W       = W'(SLOT_BASE);

    cfg_sel_e     sel;
    logic         wr_slot, wr_bo, wr_nav, wr_hold;
    logic [W-1:0] slot_reg_q;
    logic [W-1:0] slot_len;
    logic         phys_idle, nav_idle, one_slot, two_slot;

    assign sel     = cfg_sel_e'(cfg_sel);
    assign wr_slot = cfg_we && (sel == SEL_SLOT);
    assign wr_bo   = cfg_we && (sel == SEL_BACKOFF);
    assign wr_nav  = cfg_we && (sel == SEL_NAV);
    assign wr_hold = cfg_we && (sel == SEL_HOLD);

    // Slot duration register, stored in its offset encoding.
    always_ff @(posedge clk) begin
        if (!rst_n)       slot_reg_q <= DEF_SLOT_REG;
        else if (wr_slot) slot_reg_q <= cfg_wdata;
    end

    assign slot_len = (slot_reg_q >= BASE_W) ? (slot_reg_q - BASE_W) : '0;

    macslot_csense #(.W(W), .TPU(TICKS_PER_US), .DEF_HOLD_US(DEF_HOLD_US)) u_csense (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_clear  (ch_clear),
        .rx_active (rx_active),
        .tx_active (tx_active),
        .nav_load  (wr_nav),
        .nav_us    (cfg_wdata),
        .hold_load (wr_hold),
        .hold_us   (cfg_wdata),
        .phys_idle (phys_idle),
        .nav_idle  (nav_idle)
    );

    macslot_slot #(.W(W), .TPU(TICKS_PER_US), .PH2_TICKS(PH2_TICKS)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .phys_idle   (phys_idle),
        .nav_idle    (nav_idle),
        .slot_len_us (slot_len),
        .bo_load     (wr_bo),
        .bo_val      (cfg_wdata),
        .slot_q      (slot_count),
        .one_q       (one_slot),
        .two_q       (two_slot),
        .bo_q        (backoff_count),
        .idle_cnt    (idle_slots)
    );

    macslot_airtime #(.W(W), .TPU(TICKS_PER_US)) u_airtime (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_active (rx_active),
        .tx_active (tx_active),
        .busy_us   (busy_us),
        .tx_us     (tx_us)
    );

    assign backoff_zero = (backoff_count == '0);

    // Status word assembly.
    always_comb begin
        status               = '0;
        status[ST_NAV_IDLE]  = nav_idle;
        status[ST_PHYS_IDLE] = phys_idle;
        status[ST_ONE_SLOT]  = one_slot;
        status[ST_TWO_SLOT]  = two_slot;
        status[ST_BO_ZERO]   = backoff_zero;
        status[ST_RX]        = rx_active;
        status[ST_TX]        = tx_active;
        status[ST_PHASE]     = slot_count[W-1];
    end

    // R11: a backoff write of zero shows up as backoff zero on the next tick.
    p_bo_zero_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bo && cfg_wdata == '0) |=> backoff_zero)
        else $error("p_bo_zero_load_r11");
endmodule

// File: tb/tb_macslot_engine.sv
// Self-checking bench: a vector table over a programmed 3 us slot, then
// directed tests for NAV freeze, receive hold-off, airtime and reset defaults.
module tb_macslot_engine;
    timeunit 1ns;
    timeprecision 1ps;

    localparam real CLK_PERIOD = 125.0;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n, cfg_we, ch_clear, rx_active, tx_active;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic [15:0] status, slot_count, backoff_count, idle_slots, busy_us, tx_us;
    logic        backoff_zero;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    macslot_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ch_clear(ch_clear), .rx_active(rx_active),
        .tx_active(tx_active), .status(status), .backoff_zero(backoff_zero),
        .slot_count(slot_count), .backoff_count(backoff_count),
        .idle_slots(idle_slots), .busy_us(busy_us), .tx_us(tx_us)
    );

    // Offset is in ticks after the first channel-clear edge.
    typedef struct packed {
        logic [15:0] off;
        logic [15:0] slot;
        logic [15:0] stat;
        logic [15:0] bo;
        logic [15:0] idle;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{16'd7,   16'h0000, 16'h0001, 16'd3, 16'd0},
        '{16'd8,   16'h0000, 16'h0003, 16'd3, 16'd0},
        '{16'd9,   16'h0008, 16'h0003, 16'd3, 16'd0},
        '{16'd16,  16'h0001, 16'h0003, 16'd3, 16'd0},
        '{16'd17,  16'h8010, 16'h0083, 16'd3, 16'd0},
        '{16'd32,  16'h8001, 16'h0083, 16'd3, 16'd0},
        '{16'd33,  16'h0008, 16'h0007, 16'd3, 16'd0},
        '{16'd57,  16'h0008, 16'h000F, 16'd3, 16'd0},
        '{16'd81,  16'h0008, 16'h000F, 16'd2, 16'd1},
        '{16'd129, 16'h0008, 16'h001F, 16'd0, 16'd3},
        '{16'd153, 16'h0008, 16'h001F, 16'd0, 16'd4},
        '{16'd159, 16'h0002, 16'h001F, 16'd0, 16'd4}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        step(1);
        cfg_we    = 1'b0;
    endtask

    task automatic chk_reset_state();
        chk("R12 reset status", status, 16'h0011);
        chk("R12 reset slot", slot_count, 16'h0000);
        chk("R12 reset backoff", backoff_count, 16'h0000);
        chk("R12 reset idle slots", idle_slots, 16'h0000);
        chk("R12 reset busy us", busy_us, 16'h0000);
        chk("R12 reset tx us", tx_us, 16'h0000);
        chk("R11 reset backoff_zero", {15'd0, backoff_zero}, 16'h0001);
    endtask

    initial begin
        int now;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        ch_clear = 1'b0; rx_active = 1'b0; tx_active = 1'b0;
        step(3);
        chk_reset_state();
        rst_n = 1'b1;

        // Program a 3 us slot, 1 us hold-off, backoff 3, with the channel busy.
        cfg_write(2'd0, 16'h0201);
        cfg_write(2'd3, 16'd1);
        cfg_write(2'd1, 16'd3);
        step(1);
        ch_clear = 1'b1;
        now = -1;
        for (int i = 0; i < 12; i++) begin
            step(int'(VECS[i].off) - now);
            now = int'(VECS[i].off);
            chk("R1/R2 slot count", slot_count, VECS[i].slot);
            chk("R3/R8 status", status, VECS[i].stat);
            chk("R4 backoff", backoff_count, VECS[i].bo);
            chk("R4 idle slots", idle_slots, VECS[i].idle);
        end

        // R7/R5: NAV of 2 us freezes the slot and clears the flags.
        cfg_write(2'd2, 16'd2);
        step(1);
        chk("R5 slot frozen by NAV", slot_count, 16'h0001);
        chk("R7 NAV busy status", status, 16'h0012);
        step(14);
        chk("R7 NAV still busy", status, 16'h0012);
        chk("R5 slot still frozen", slot_count, 16'h0001);
        step(1);
        chk("R7 NAV idle again", status, 16'h0013);
        step(1);
        chk("R2 phase 2 after NAV", slot_count, 16'h8010);
        step(16);
        chk("R3 one-slot after restart", status, 16'h0017);
        chk("R6 NAV keeps idle slots", idle_slots, 16'd4);

        // R8/R9: receive for 16 ticks, then hold-off of 1 us.
        rx_active = 1'b1;
        step(16);
        chk("R9 busy us after rx", busy_us, 16'd2);
        chk("R5 slot frozen by rx", slot_count, 16'h0007);
        chk("R8 rx status", status, 16'h0031);
        rx_active = 1'b0;
        step(8);
        chk("R8 hold-off not expired", status, 16'h0011);
        step(1);
        chk("R8 idle rises after hold-off", status, 16'h0013);
        chk("R6 idle slots before reload", idle_slots, 16'd4);
        step(1);
        chk("R1 reload on idle rise", slot_count, 16'h0008);
        chk("R6 idle slots cleared", idle_slots, 16'd0);

        // R10/R9: transmit airtime.
        tx_active = 1'b1;
        step(20);
        chk("R10 tx us", tx_us, 16'd2);
        chk("R9 busy us with tx", busy_us, 16'd4);
        chk("R12 tx status", status, 16'h0051);
        tx_active = 1'b0;
        step(3);
        tx_active = 1'b1;
        step(1);
        chk("R10 tx restart clears", tx_us, 16'd0);
        step(7);
        chk("R10 tx after 8 ticks", tx_us, 16'd1);
        chk("R9 busy us accumulates", busy_us, 16'd5);
        tx_active = 1'b0;

        // R11: backoff load and zero flag.
        cfg_write(2'd1, 16'd5);
        chk("R11 backoff loaded", backoff_count, 16'd5);
        chk("R11 backoff_zero low", {15'd0, backoff_zero}, 16'd0);
        chk("R11 status zero bit low", {15'd0, status[4]}, 16'd0);
        cfg_write(2'd1, 16'd0);
        chk("R11 backoff_zero high", {15'd0, backoff_zero}, 16'd1);

        // R12/R8/R1: reset again and check the default hold-off and slot.
        rst_n = 1'b0;
        step(3);
        chk_reset_state();
        rst_n = 1'b1;
        rx_active = 1'b1;
        step(1);
        rx_active = 1'b0;
        step(48);
        chk("R8 default hold-off pending", status, 16'h0011);
        step(1);
        chk("R8 default hold-off done", status, 16'h0013);
        step(1);
        chk("R1 default slot load", slot_count, 16'd56);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule